// File: doc/BRIEF.md
# Sizable Memory Base Address Register

This block is one memory base address register of an endpoint's configuration space. It can also be a linked pair of registers that holds a 64-bit base. The window size is fixed by a parameter and is always a power of two. Configuration software reaches the block through a 32-bit register port with a word select. It finds the window size by writing all ones and reading the value back. It then programs a base, and the block decodes incoming memory addresses against that base.

A parameter picks one of three kinds. The first is an unused slot, which reads as zero. The second is a 32-bit memory register. The third is a 64-bit memory register made of a lower and an upper word. The low nibble of the lower word carries fixed type flags. Address bits below the window size are tied to zero, so the readback after an all-ones write shows the size. The decode is gated by the memory-space enable bit of the command register, which arrives on an input pin.

Top module: `sizable_bar`

## Requirements
- R1: Bits [3:0] of the lower word are read-only. Bit 0 reads 0. Bits [2:1] read 00 for the 32-bit kind and 10 for the 64-bit kind. Bit 3 reads the prefetchable parameter. An unused slot reads 0000.
- R2: Address bits below SIZE_LOG2 always read zero, whatever value was written to them.
- R3: After all ones is written, the lower word reads back the size mask with the flags. Clearing bits [3:0] of the combined readback and taking the two's complement gives 2^SIZE_LOG2.
- R4: In the 64-bit kind, word select 0 holds base bits [31:0] and word select 1 holds base bits [63:32]. A write to one word leaves the other word unchanged.
- R5: The unused kind ignores writes to both words, always reads zero, and never reports a hit.
- R6: In the 32-bit kind, word select 1 reads zero and ignores writes. The base bits [63:32] stay zero.
- R7: With memory-space enable set, req_hit is 1 exactly when req_addr ANDed with the size mask equals the programmed base. In the 32-bit kind, an address with any bit of [63:32] set misses.
- R8: With memory-space enable clear, req_hit is 0 for every address.
- R9: A synchronous active-high reset clears every writable base bit. The flag bits are not changed by reset.
- R10: A write takes effect on bar_base at the clock edge where cfg_wr is sampled high. Without a write, bar_base holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 is the lower word, 1 is the upper word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected word (combinational) |
| mem_space_en | input | 1 | Memory-space enable bit from the command register |
| req_addr | input | 64 | Incoming memory address to decode |
| req_hit | output | 1 | Address falls inside the programmed window (combinational) |
| bar_base | output | 64 | Programmed base address, low bits zero |

## Verification
The assertions check the following on every cycle:
- the fixed flag nibble and the zero low address bits on the lower word;
- the silence of an unused slot and of the upper word in the 32-bit kind;
- the gating by memory-space enable;
- the base update after each write, and its hold when there is no write;
- the decode equation.

Only the bench's scenarios can show the remaining behaviour: that the all-ones readback yields the right size when converted the way software converts it, that a real base programmed over two separate writes places the window where software expects, and that the edges of the window fall exactly one size apart. The bench shows these by sweeping data patterns and window-relative addresses over three small configurations.

// File: rtl/bar_pkg.sv
package bar_pkg;

    typedef enum logic [1:0] {
        BAR_OFF   = 2'd0,
        BAR_MEM32 = 2'd1,
        BAR_MEM64 = 2'd2
    } bar_kind_e;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 64;
    localparam int FLAG_W = 4;

    // Mask of the address bits that take part in the decode.
    function automatic logic [ADDR_W-1:0] decode_mask(bar_kind_e kind, int size_log2);
        logic [ADDR_W-1:0] m;
        m = ~((64'd1 << size_log2) - 64'd1);
        if (kind == BAR_OFF) m = '0;
        return m;
    endfunction

    // Mask of the bits that software can write.
    function automatic logic [ADDR_W-1:0] write_mask(bar_kind_e kind, int size_log2);
        logic [ADDR_W-1:0] m;
        m = decode_mask(kind, size_log2);
        if (kind == BAR_MEM32) m = m & 64'h0000_0000_FFFF_FFFF;
        return m;
    endfunction

    // Read-only type nibble: bit0 memory, bits[2:1] width, bit3 prefetchable.
    function automatic logic [FLAG_W-1:0] type_flags(bar_kind_e kind, logic prefetch);
        logic [FLAG_W-1:0] f;
        f = '0;
        if (kind != BAR_OFF) begin
            f[3]   = prefetch;
            f[2:1] = (kind == BAR_MEM64) ? 2'b10 : 2'b00;
            f[0]   = 1'b0;
        end
        return f;
    endfunction

endpackage

// File: rtl/bar_word.sv
module bar_word
    import bar_pkg::*;
#(
    parameter logic [WORD_W-1:0] WMASK  = '0,
    parameter logic [WORD_W-1:0] ROBITS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)     q_r <= '0;
        else if (wr) q_r <= wdata & WMASK;
    end

    assign q     = q_r;
    assign rdata = q_r | ROBITS;
endmodule

// File: rtl/bar_decode.sv
module bar_decode
    import bar_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DMASK = '0,
    parameter bit                ACTIVE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              mem_en,
    output logic              hit
);
    generate
        if (ACTIVE) begin : g_live
            logic match;
            assign match = ((addr & DMASK) == base);
            assign hit   = mem_en & match;
        end else begin : g_dead
            assign hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sizable_bar.sv
module sizable_bar
    import bar_pkg::*;
#(
    parameter bar_kind_e KIND      = BAR_MEM64,
    parameter int        SIZE_LOG2 = 12,
    parameter bit        PREFETCH  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mem_space_en,
    input  logic [63:0] req_addr,
    output logic        req_hit,
    output logic [63:0] bar_base
);
    localparam logic [ADDR_W-1:0] WM = write_mask(KIND, SIZE_LOG2);
    localparam logic [ADDR_W-1:0] DM = decode_mask(KIND, SIZE_LOG2);
    localparam logic [FLAG_W-1:0] FL = type_flags(KIND, PREFETCH);
    localparam int                NWORDS = ADDR_W / WORD_W;

    logic [WORD_W-1:0] word_q  [NWORDS];
    logic [WORD_W-1:0] word_rd [NWORDS];

    genvar g;
    generate
        for (g = 0; g < NWORDS; g++) begin : g_word
            localparam logic [WORD_W-1:0] RO =
                (g == 0) ? {{(WORD_W-FLAG_W){1'b0}}, FL} : '0;
            bar_word #(
                .WMASK  (WM[g*WORD_W +: WORD_W]),
                .ROBITS (RO)
            ) u_word (
                .clk   (clk),
                .rst   (rst),
                .wr    (cfg_wr && (cfg_sel == 1'(g))),
                .wdata (cfg_wdata),
                .q     (word_q[g]),
                .rdata (word_rd[g])
            );
        end
    endgenerate

    assign cfg_rdata = word_rd[cfg_sel];
    assign bar_base  = {word_q[1], word_q[0]};

    bar_decode #(
        .DMASK  (DM),
        .ACTIVE (KIND != BAR_OFF)
    ) u_dec (
        .addr   (req_addr),
        .base   (bar_base),
        .mem_en (mem_space_en),
        .hit    (req_hit)
    );
endmodule

// File: rtl/bar_chk.sv
module bar_chk
    import bar_pkg::*;
#(
    parameter bar_kind_e KIND      = BAR_MEM64,
    parameter int        SIZE_LOG2 = 12,
    parameter bit        PREFETCH  = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic        cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        mem_space_en,
    input logic [63:0] req_addr,
    input logic        req_hit,
    input logic [63:0] bar_base
);
    localparam logic [63:0] M64 = ~((64'd1 << SIZE_LOG2) - 64'd1);
    localparam logic [63:0] MW  = (KIND == BAR_MEM64) ? M64 :
                                  (KIND == BAR_MEM32) ? (M64 & 64'h0000_0000_FFFF_FFFF) : 64'd0;
    localparam logic [31:0] LOWZ = ~M64[31:0];
    localparam logic [3:0]  EXPF = (KIND == BAR_OFF)   ? 4'h0 :
                                   (KIND == BAR_MEM64) ? {PREFETCH, 3'b100} : {PREFETCH, 3'b000};

    initial begin
        a_size_min: assert (SIZE_LOG2 >= 4)
            else $error("window size below 16 bytes");
        a_size_max: assert (SIZE_LOG2 <= ((KIND == BAR_MEM64) ? 63 : 31))
            else $error("window size too large for kind");
    end

    p_flags_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |-> cfg_rdata[3:0] == EXPF);

    p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sel && KIND != BAR_OFF) |-> (cfg_rdata & LOWZ & 32'hFFFF_FFF0) == 32'h0);

    p_word_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_sel) |=> bar_base[31:0] == ($past(cfg_wdata) & MW[31:0]));

    p_word_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel) |=> bar_base[63:32] == ($past(cfg_wdata) & MW[63:32]));

    p_off_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (KIND == BAR_OFF) |-> (cfg_rdata == 32'h0 && !req_hit && bar_base == 64'h0));

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (KIND == BAR_MEM32) |-> (bar_base[63:32] == 32'h0 && (!cfg_sel || cfg_rdata == 32'h0)));

    p_hit_eq_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_space_en && KIND != BAR_OFF) |-> req_hit == ((req_addr & M64) == bar_base));

    p_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_space_en |-> !req_hit);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(bar_base));
endmodule

bind sizable_bar bar_chk #(
    .KIND      (KIND),
    .SIZE_LOG2 (SIZE_LOG2),
    .PREFETCH  (PREFETCH)
) u_chk (.*);

// File: tb/sim_sizable_bar.sv
module sim_sizable_bar;
    import bar_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_space_en = 1'b0;
    logic [63:0] req_addr = '0;

    logic [31:0] rd0, rd1, rd2;
    logic        hit0, hit1, hit2;
    logic [63:0] base0, base1, base2;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sizable_bar #(.KIND(BAR_MEM64), .SIZE_LOG2(12), .PREFETCH(1'b1)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd0), .mem_space_en(mem_space_en), .req_addr(req_addr),
        .req_hit(hit0), .bar_base(base0));
    sizable_bar #(.KIND(BAR_MEM32), .SIZE_LOG2(8), .PREFETCH(1'b0)) u1 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd1), .mem_space_en(mem_space_en), .req_addr(req_addr),
        .req_hit(hit1), .bar_base(base1));
    sizable_bar #(.KIND(BAR_OFF), .SIZE_LOG2(12), .PREFETCH(1'b1)) u2 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd2), .mem_space_en(mem_space_en), .req_addr(req_addr),
        .req_hit(hit2), .bar_base(base2));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic sel_word(input logic sel);
        @(negedge clk);
        cfg_sel = sel;
        #1;
    endtask

    // expected bases held by the bench
    logic [31:0] e0_lo, e0_hi, e1_lo;

    initial begin
        logic [63:0] sz;
        logic [63:0] b0, b1;
        logic [31:0] d;
        logic [63:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 / R1: reset state and flag nibble
        sel_word(1'b0);
        check("R9 u0 lo after reset", {32'h0, rd0}, 64'hC);
        check("R1 u1 flags", {32'h0, rd1}, 64'h0);
        check("R5 u2 reads zero", {32'h0, rd2}, 64'h0);
        check("R9 u0 base", base0, 64'h0);
        check("R9 u1 base", base1, 64'h0);

        // R3: sizing probe
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        sel_word(1'b0);
        check("R3 u0 lo probe", {32'h0, rd0}, 64'hFFFF_F00C);
        check("R3 u1 lo probe", {32'h0, rd1}, 64'hFFFF_FF00);
        check("R5 u2 probe lo", {32'h0, rd2}, 64'h0);
        b0 = {32'h0, rd0 & 32'hFFFF_FFF0};
        b1 = {32'h0, rd1 & 32'hFFFF_FFF0};
        sel_word(1'b1);
        check("R3 u0 hi probe", {32'h0, rd0}, 64'hFFFF_FFFF);
        check("R6 u1 hi reads zero", {32'h0, rd1}, 64'h0);
        check("R5 u2 probe hi", {32'h0, rd2}, 64'h0);
        sz = ~({rd0, 32'h0} | b0) + 64'd1;
        check("R3 u0 size", sz, 64'h1000);
        sz = {32'h0, ~b1[31:0] + 32'd1};
        check("R3 u1 size", sz, 64'h100);

        // R2 / R4 / R6 / R10: pattern sweep over both words
        e0_lo = 32'hFFFF_F000; e0_hi = 32'hFFFF_FFFF; e1_lo = 32'hFFFF_FF00;
        for (int i = 0; i < 24; i++) begin
            d = (32'h9E37_79B9 * (i + 1)) ^ (32'h0000_0FFF >> (i % 12));
            if (i % 2 == 0) begin
                cfg_write(1'b0, d);
                e0_lo = d & 32'hFFFF_F000;
                e1_lo = d & 32'hFFFF_FF00;
            end else begin
                cfg_write(1'b1, d);
                e0_hi = d;
            end
            check("R10 u0 base", base0, {e0_hi, e0_lo});
            check("R6 u1 base", base1, {32'h0, e1_lo});
            check("R5 u2 base", base2, 64'h0);
            sel_word(1'b0);
            check("R2 u0 lo", {32'h0, rd0}, {32'h0, e0_lo | 32'hC});
            check("R2 u1 lo", {32'h0, rd1}, {32'h0, e1_lo});
            sel_word(1'b1);
            check("R4 u0 hi", {32'h0, rd0}, {32'h0, e0_hi});
            check("R6 u1 hi", {32'h0, rd1}, 64'h0);
        end

        // R7 / R8: decode sweep around programmed windows
        cfg_write(1'b0, 32'h4000_3ABC);
        cfg_write(1'b1, 32'h0000_0001);
        b0 = 64'h0000_0001_4000_3000;
        b1 = 64'h0000_0000_4000_3A00;
        check("R4 u0 base programmed", base0, b0);
        check("R4 u1 base programmed", base1, b1);
        for (int en = 0; en < 2; en++) begin
            for (int k = -40; k < 40; k++) begin
                @(negedge clk);
                mem_space_en = en[0];
                a = b0 + 64'(signed'(k) * 64'sd129);
                req_addr = a;
                #1;
                check(en ? "R7 u0 hit" : "R8 u0 gated", {63'h0, hit0},
                      {63'h0, en[0] && ((a >> 12) == (b0 >> 12))});
                check("R5 u2 never hits", {63'h0, hit2}, 64'h0);
                a = b1 + 64'(signed'(k) * 64'sd7);
                req_addr = a;
                #1;
                check(en ? "R7 u1 hit" : "R8 u1 gated", {63'h0, hit1},
                      {63'h0, en[0] && ((a >> 8) == (b1 >> 8))});
            end
        end
        @(negedge clk);
        mem_space_en = 1'b1;
        req_addr = b1 | 64'h0000_0100_0000_0000;
        #1;
        check("R7 u1 upper bits miss", {63'h0, hit1}, 64'h0);
        req_addr = b1 + 64'hFF;
        #1;
        check("R7 u1 top of window", {63'h0, hit1}, 64'h1);
        req_addr = b0 + 64'hFFF;
        #1;
        check("R7 u0 top of window", {63'h0, hit0}, 64'h1);
        req_addr = b0 + 64'h1000;
        #1;
        check("R7 u0 past window", {63'h0, hit0}, 64'h0);

        // R9: reset clears the base, flags stay
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        sel_word(1'b0);
        check("R9 u0 base cleared", base0, 64'h0);
        check("R9 u0 flags kept", {32'h0, rd0}, 64'hC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule